// File: doc/BRIEF.md
# Flash program/erase command engine

This block sequences erase, program and info-read operations on a two-bank on-chip flash array. Software loads a word write buffer and a transfer register that holds a word offset, a region select (main bank or the separate info region) and a zero-based word count. It then writes an unlock key and, as the very next register access, a 32-bit opcode into the control register of the target bank. The control register reads back the opcode while the operation runs and reads zero once the operation has finished. Writing zero to it cancels the running operation.

Only one operation runs at a time. Reads of the bank that is busy are stalled for the whole operation, and reads of the other bank continue. The cells follow flash rules: erase returns words to all ones, and programming ANDs the new data into the stored value, so bits can only go from 1 to 0. A behavioural array with latencies set by parameters stands in for the cells. Bank and page sizes must be powers of two.

Register word addresses: 0 key, 1 bank-0 control, 2 bank-1 control, 3 transfer, 4 error status, 5 info-read result, 32+i write-buffer word i. Main-array read addresses put the bank in the most significant bit.

Top module: `flash_pe_ctrl`

## Requirements
- R1: After reset every main-array word reads 0xFFFFFFFF, and both control registers and the error register read 0.
- R2: An opcode write starts an operation only if the register access just before it was a write of 0xB11924E1 to address 0. Any other access in between, a wrong key value, or a missing key causes the opcode to be ignored. Each opcode write uses up the key, so the next opcode needs a new key.
- R3: Only 0x31415927 (erase), 0x27182818 (program) and 0x16021765 (info read) start an operation. Any other value has no effect on the array, the control registers or the error register.
- R4: The transfer register has the word offset in bits [31:7], info select in bit 6, whole-bank in bit 5 and the word count minus one in bits [4:0]. A program operation ANDs write-buffer word i into word offset+i for i = 0..count-1, in the bank whose control register was written.
- R5: A main erase with bit 5 clear sets to all ones the page (PAGE_WORDS words) that holds the offset. With bit 5 set, it sets the whole bank to all ones.
- R6: With bit 6 set, operations target the info region and must be issued through the bank-1 control register. An info erase sets every info word to all ones, an info program ANDs as in R4, and an info read puts info word [offset] into register 5 when it completes.
- R7: A command whose target is out of range starts nothing and sets error bit 0. This covers a main offset or offset+count past the end of the bank, an info range past the end of the region, an info command through bank 0, and an info read without bit 6.
- R8: While an operation is busy, its control register reads the opcode. The operation stays busy for exactly ERASE_CYC, PROG_CYC or READ_CYC cycles, and its control register then reads 0.
- R9: mem_stall_o is high for a read of the busy bank for the whole operation. Reads of the other bank are not stalled and return stored data.
- R10: Writing 0 to the busy bank's control register ends the operation at once, leaves the array unchanged and sets error bit 1.
- R11: Reading the error register returns its bits and clears them.
- R12: A control-register write made while an operation is busy starts nothing, even if a key was written just before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_req_i | input | 1 | Register access strobe, one cycle per access |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 6 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| mem_rd_i | input | 1 | Main-array read request |
| mem_addr_i | input | MA_W | Main-array word address, MSB selects the bank |
| mem_rdata_o | output | 32 | Main-array read data |
| mem_stall_o | output | 1 | Read targets the busy bank and must wait |

## Verification
The bench sweeps program offsets and counts across both banks, including the last word and the full-bank count, against an AND-only model. A design that overwrote words instead of ANDing, or that was off by one on the count, would leave words that do not match. Every single-bit corruption of the erase opcode is tried, along with a missing key, an interposed access, a wrong key and a reused key; a lax key or opcode check would let one of these erase a page. The bench counts the stall cycles of each operation kind and reads the other bank at the same time, which exposes a counter that is off by one or a stall that covers both banks. Abort, rejected ranges and a command issued while busy are each checked for an untouched array and for the exact error bits, which are cleared on read.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;
  localparam logic [31:0] KEY_VAL  = 32'hB119_24E1;
  localparam logic [31:0] OPC_ERASE = 32'h3141_5927;
  localparam logic [31:0] OPC_PROG  = 32'h2718_2818;
  localparam logic [31:0] OPC_IREAD = 32'h1602_1765;

  localparam logic [5:0] A_KEY  = 6'h00;
  localparam logic [5:0] A_CTL0 = 6'h01;
  localparam logic [5:0] A_CTL1 = 6'h02;
  localparam logic [5:0] A_XFER = 6'h03;
  localparam logic [5:0] A_ERR  = 6'h04;
  localparam logic [5:0] A_DOUT = 6'h05;

  typedef enum logic [1:0] {K_NONE, K_ERASE, K_PROG, K_IREAD} op_e;

  typedef struct packed {
    logic [24:0] off;
    logic        info;
    logic        whole;
    logic [4:0]  size;
  } xfer_t;
endpackage

// File: rtl/flash_key_gate.sv
module flash_key_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic acc_i,
  input  logic key_hit_i,
  output logic armed_o
);
  // Any register access re-evaluates the arm state.
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    armed_o <= 1'b0;
    else if (acc_i) armed_o <= key_hit_i;
endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
  import flash_pe_pkg::*;
#(
  parameter int BANK_WORDS = 32,
  parameter int INFO_WORDS = 16,
  parameter int WBUF_WORDS = 32,
  parameter int ERASE_CYC  = 20,
  parameter int PROG_CYC   = 12,
  parameter int READ_CYC   = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ctl_wr_i,
  input  logic        ctl_bank_i,
  input  logic [31:0] ctl_data_i,
  input  logic        armed_i,
  input  xfer_t       xfer_i,
  output logic        busy_o,
  output logic        bank_o,
  output op_e         op_o,
  output logic [31:0] opcode_o,
  output xfer_t       cmd_o,
  output logic        done_o,
  output logic        reject_o,
  output logic        abort_o
);
  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  localparam int LAT_MAX = max3(ERASE_CYC, PROG_CYC, READ_CYC);
  localparam int CNT_W   = $clog2(LAT_MAX + 1);

  logic [CNT_W-1:0] cnt_q, lat;
  op_e              dec;
  logic             ok, launch;
  logic [25:0]      end_w;

  always_comb begin
    unique case (ctl_data_i)
      OPC_ERASE: dec = K_ERASE;
      OPC_PROG:  dec = K_PROG;
      OPC_IREAD: dec = K_IREAD;
      default:   dec = K_NONE;
    endcase
  end

  assign end_w = 26'(xfer_i.off) + 26'(xfer_i.size);

  always_comb begin
    unique case (dec)
      K_ERASE: ok = xfer_i.info ? ctl_bank_i
                                : (xfer_i.whole || (26'(xfer_i.off) < 26'(BANK_WORDS)));
      K_PROG:  ok = (32'(xfer_i.size) < 32'(WBUF_WORDS)) &&
                    (xfer_i.info ? (ctl_bank_i && end_w < 26'(INFO_WORDS))
                                 : (end_w < 26'(BANK_WORDS)));
      K_IREAD: ok = xfer_i.info && ctl_bank_i && (26'(xfer_i.off) < 26'(INFO_WORDS));
      default: ok = 1'b0;
    endcase
  end

  always_comb begin
    unique case (dec)
      K_ERASE: lat = CNT_W'(ERASE_CYC);
      K_PROG:  lat = CNT_W'(PROG_CYC);
      default: lat = CNT_W'(READ_CYC);
    endcase
  end

  assign launch   = ctl_wr_i && !busy_o && armed_i && (dec != K_NONE);
  assign reject_o = launch && !ok;
  assign abort_o  = ctl_wr_i && busy_o && (ctl_bank_i == bank_o) && (ctl_data_i == 32'd0);
  assign done_o   = busy_o && !abort_o && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o   <= 1'b0;
      cnt_q    <= '0;
      bank_o   <= 1'b0;
      op_o     <= K_NONE;
      opcode_o <= '0;
      cmd_o    <= '0;
    end else if (launch && ok) begin
      busy_o   <= 1'b1;
      cnt_q    <= lat;
      bank_o   <= ctl_bank_i;
      op_o     <= dec;
      opcode_o <= ctl_data_i;
      cmd_o    <= xfer_i;
    end else if (busy_o) begin
      if (abort_o || cnt_q == CNT_W'(1)) begin
        busy_o <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q - CNT_W'(1);
      end
    end
  end

  p_cnt_live_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cnt_q != '0));
  p_abort_stops_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !busy_o);
  p_busy_locked_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && !abort_o) |=> ($stable(opcode_o) && $stable(bank_o)));
endmodule

// File: rtl/flash_store.sv
module flash_store
  import flash_pe_pkg::*;
#(
  parameter int BANK_WORDS = 32,
  parameter int PAGE_WORDS = 8,
  parameter int INFO_WORDS = 16,
  parameter int WBUF_WORDS = 32,
  localparam int MW = $clog2(2 * BANK_WORDS),
  localparam int IW = $clog2(INFO_WORDS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        done_i,
  input  op_e                         op_i,
  input  logic                        bank_i,
  input  xfer_t                       cmd_i,
  input  logic [WBUF_WORDS-1:0][31:0] wbuf_i,
  input  logic [MW-1:0]               rd_addr_i,
  output logic [31:0]                 rd_data_o,
  output logic [31:0]                 dout_o
);
  logic [31:0] main_q [2*BANK_WORDS];
  logic [31:0] info_q [INFO_WORDS];
  logic [31:0] w0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < 2 * BANK_WORDS; k++) main_q[k] <= '1;
      for (int j = 0; j < INFO_WORDS; j++)     info_q[j] <= '1;
      dout_o <= '0;
    end else if (done_i) begin
      unique case (op_i)
        K_ERASE: begin
          if (cmd_i.info) begin
            for (int j = 0; j < INFO_WORDS; j++) info_q[j] <= '1;
          end else begin
            for (int k = 0; k < 2 * BANK_WORDS; k++)
              if ((k / BANK_WORDS) == int'(bank_i) &&
                  (cmd_i.whole ||
                   ((k % BANK_WORDS) / PAGE_WORDS) == (int'(cmd_i.off) / PAGE_WORDS)))
                main_q[k] <= '1;
          end
        end
        K_PROG: begin
          for (int i = 0; i < WBUF_WORDS; i++)
            if (i <= int'(cmd_i.size)) begin
              if (cmd_i.info)
                info_q[IW'(int'(cmd_i.off) + i)] <=
                  info_q[IW'(int'(cmd_i.off) + i)] & wbuf_i[i];
              else
                main_q[MW'(int'(bank_i) * BANK_WORDS + int'(cmd_i.off) + i)] <=
                  main_q[MW'(int'(bank_i) * BANK_WORDS + int'(cmd_i.off) + i)] & wbuf_i[i];
            end
        end
        K_IREAD: dout_o <= info_q[IW'(cmd_i.off)];
        default: ;
      endcase
    end
  end

  assign rd_data_o = main_q[rd_addr_i];
  assign w0        = main_q[0];

  // Outside erase, a word can only lose ones.
  p_only_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_i && op_i == K_ERASE) |=> ((w0 & ~$past(w0)) == 32'd0));
endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
  import flash_pe_pkg::*;
#(
  parameter int BANK_PAGES = 4,
  parameter int PAGE_WORDS = 8,
  parameter int INFO_WORDS = 16,
  parameter int WBUF_WORDS = 32,
  parameter int ERASE_CYC  = 20,
  parameter int PROG_CYC   = 12,
  parameter int READ_CYC   = 4,
  localparam int BANK_WORDS = BANK_PAGES * PAGE_WORDS,
  localparam int MA_W       = $clog2(2 * BANK_WORDS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_req_i,
  input  logic            reg_we_i,
  input  logic [5:0]      reg_addr_i,
  input  logic [31:0]     reg_wdata_i,
  output logic [31:0]     reg_rdata_o,
  input  logic            mem_rd_i,
  input  logic [MA_W-1:0] mem_addr_i,
  output logic [31:0]     mem_rdata_o,
  output logic            mem_stall_o
);
  logic [WBUF_WORDS-1:0][31:0] wbuf_q;
  xfer_t       xfer_q, cmd;
  logic [1:0]  err_q;
  logic [31:0] opcode, dout;
  logic        armed, key_hit, ctl_wr, ctl_bank, busy, bank, done, reject, abort, err_rd;
  op_e         op;

  assign key_hit  = reg_we_i && reg_addr_i == A_KEY && reg_wdata_i == KEY_VAL;
  assign ctl_wr   = reg_req_i && reg_we_i && (reg_addr_i == A_CTL0 || reg_addr_i == A_CTL1);
  assign ctl_bank = reg_addr_i == A_CTL1;
  assign err_rd   = reg_req_i && !reg_we_i && reg_addr_i == A_ERR;

  flash_key_gate u_key (
    .clk_i, .rst_ni, .acc_i(reg_req_i), .key_hit_i(key_hit), .armed_o(armed)
  );

  flash_op_seq #(
    .BANK_WORDS(BANK_WORDS), .INFO_WORDS(INFO_WORDS), .WBUF_WORDS(WBUF_WORDS),
    .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC), .READ_CYC(READ_CYC)
  ) u_seq (
    .clk_i, .rst_ni,
    .ctl_wr_i(ctl_wr), .ctl_bank_i(ctl_bank), .ctl_data_i(reg_wdata_i),
    .armed_i(armed), .xfer_i(xfer_q),
    .busy_o(busy), .bank_o(bank), .op_o(op), .opcode_o(opcode), .cmd_o(cmd),
    .done_o(done), .reject_o(reject), .abort_o(abort)
  );

  flash_store #(
    .BANK_WORDS(BANK_WORDS), .PAGE_WORDS(PAGE_WORDS),
    .INFO_WORDS(INFO_WORDS), .WBUF_WORDS(WBUF_WORDS)
  ) u_store (
    .clk_i, .rst_ni, .done_i(done), .op_i(op), .bank_i(bank), .cmd_i(cmd),
    .wbuf_i(wbuf_q), .rd_addr_i(mem_addr_i), .rd_data_o(mem_rdata_o), .dout_o(dout)
  );

  for (genvar g = 0; g < WBUF_WORDS; g++) begin : g_wbuf
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) wbuf_q[g] <= '1;
      else if (reg_req_i && reg_we_i && reg_addr_i == 6'(32 + g)) wbuf_q[g] <= reg_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xfer_q <= '0;
      err_q  <= '0;
    end else begin
      if (reg_req_i && reg_we_i && reg_addr_i == A_XFER) xfer_q <= reg_wdata_i;
      // new events win over the read-clear
      err_q <= (err_rd ? 2'b00 : err_q) | {abort, reject};
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i[5]) begin
      for (int i = 0; i < WBUF_WORDS; i++)
        if (int'(reg_addr_i[4:0]) == i) reg_rdata_o = wbuf_q[i];
    end else begin
      unique case (reg_addr_i)
        A_CTL0:  reg_rdata_o = (busy && !bank) ? opcode : '0;
        A_CTL1:  reg_rdata_o = (busy &&  bank) ? opcode : '0;
        A_XFER:  reg_rdata_o = xfer_q;
        A_ERR:   reg_rdata_o = {30'd0, err_q};
        A_DOUT:  reg_rdata_o = dout;
        default: reg_rdata_o = '0;
      endcase
    end
  end

  assign mem_stall_o = mem_rd_i && busy && (mem_addr_i[MA_W-1] == bank);

  p_stall_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_stall_o |-> busy);
  p_start_keyed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(armed));
  p_err_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_rd && !reject && !abort) |=> (err_q == 2'b00));
endmodule

// File: tb/test_flash_pe_ctrl.sv
`timescale 1ns/100ps
module test_flash_pe_ctrl;
  localparam int PW = 8, BW = 32, IWD = 16, WB = 32, EC = 20, PC = 12, RC = 4;
  localparam logic [31:0] KEY = 32'hB119_24E1, OE = 32'h3141_5927,
                          OP = 32'h2718_2818, OR = 32'h1602_1765;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req = 0, we = 0, mrd_en = 0, stall;
  logic [5:0]  addr = 0;
  logic [31:0] wdata = 0, rdata, mdata;
  logic [5:0]  maddr = 0;

  flash_pe_ctrl i_flash_pe_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mem_rd_i(mrd_en), .mem_addr_i(maddr),
    .mem_rdata_o(mdata), .mem_stall_o(stall)
  );

  int total = 0, bad = 0;
  logic [31:0] m_main [2*BW];
  logic [31:0] m_info [IWD];
  logic [31:0] wb [WB];

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #0.5 req = 0; we = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a; #1 d = rdata;
    @(posedge clk); #0.5 req = 0;
  endtask

  task automatic mrd(int a, output logic [31:0] d, output logic s);
    @(negedge clk); mrd_en = 1; maddr = 6'(a); #1 d = mdata; s = stall;
  endtask

  task automatic cmp_main(string tag);
    logic [31:0] d; logic s; bit ok = 1;
    for (int k = 0; k < 2 * BW; k++) begin
      mrd(k, d, s);
      if (ok && (d !== m_main[k] || s)) begin chk(tag, d, m_main[k]); ok = 0; end
    end
    if (ok) chk(tag, 0, 0);
  endtask

  task automatic set_xfer(int off, bit info, bit whole, int size);
    wr(6'h03, {25'(off), info, whole, 5'(size)});
  endtask

  task automatic launch(bit b, logic [31:0] opc);
    wr(6'h00, KEY); wr(b ? 6'h02 : 6'h01, opc);
  endtask

  task automatic wait_idle(bit b);
    logic [31:0] d;
    for (int n = 0; n < 100; n++) begin
      rd(b ? 6'h02 : 6'h01, d);
      if (d == 0) break;
    end
  endtask

  task automatic fill_wb(int salt);
    for (int i = 0; i < WB; i++) begin
      wb[i] = ~((32'h1 << ((i + salt) % 32)) | ((32'(salt) * 32'h9E37_79B1 ^ 32'(i) * 32'h0101_0101) & 32'h0F0F_0F0F));
      wr(6'(32 + i), wb[i]);
    end
  endtask

  task automatic do_prog(bit b, bit info, int off, int size);
    set_xfer(off, info, 0, size);
    launch(b, OP);
    wait_idle(b);
    for (int i = 0; i <= size; i++)
      if (info) m_info[off + i] &= wb[i];
      else      m_main[int'(b) * BW + off + i] &= wb[i];
  endtask

  // launch, probe the other bank once, then count stall cycles on the busy bank
  task automatic lat_probe(string tag, bit b, logic [31:0] opc, int lat);
    logic [31:0] d; logic s; int n = 0;
    launch(b, opc);
    mrd((b ? 0 : BW) + 3, d, s);
    chk({tag, " R9 other bank"}, {31'd0, s}, 0);
    chk({tag, " R9 other data"}, d, m_main[(b ? 0 : BW) + 3]);
    for (int k = 0; k < 100; k++) begin
      mrd(int'(b) * BW + 1, d, s);
      if (!s) break;
      n++;
    end
    chk({tag, " R8 busy cycles"}, 32'(n), 32'(lat - 1));
  endtask

  initial begin
    #(5.0 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int k = 0; k < 2 * BW; k++) m_main[k] = '1;
    for (int j = 0; j < IWD; j++)    m_info[j] = '1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    cmp_main("R1 array erased");
    rd(6'h01, d); chk("R1 ctl0", d, 0);
    rd(6'h02, d); chk("R1 ctl1", d, 0);
    rd(6'h04, d); chk("R1 err", d, 0);

    // R4 program sweep over both banks
    begin
      int offs [6] = '{0, 3, 10, 31, 0, 16};
      int szs  [6] = '{0, 4, 21, 0, 31, 15};
      for (int b = 0; b < 2; b++)
        for (int t = 0; t < 6; t++) begin
          fill_wb(b * 7 + t);
          do_prog(b[0], 0, offs[t], szs[t]);
          cmp_main($sformatf("R4 prog b%0d off%0d cnt%0d", b, offs[t], szs[t] + 1));
        end
    end
    rd(6'h04, d); chk("R4 no error", d, 0);

    // R5 page erase and whole-bank erase
    set_xfer(9, 0, 0, 0); launch(0, OE); wait_idle(0);
    for (int k = 8; k < 16; k++) m_main[k] = '1;
    cmp_main("R5 page erase");
    set_xfer(0, 0, 1, 0); launch(1, OE); wait_idle(1);
    for (int k = BW; k < 2 * BW; k++) m_main[k] = '1;
    cmp_main("R5 bank erase");

    // R8 / R9 latency per operation kind, with readback of the opcode
    fill_wb(40);
    set_xfer(2, 0, 0, 3); lat_probe("prog", 0, OP, PC);
    for (int i = 0; i <= 3; i++) m_main[2 + i] &= wb[i];
    set_xfer(0, 0, 0, 0); lat_probe("erase", 1, OE, EC);
    set_xfer(1, 1, 0, 0); lat_probe("iread", 1, OR, RC);
    cmp_main("R8 after probes");
    set_xfer(5, 0, 0, 0); launch(0, OE);
    rd(6'h01, d); chk("R8 ctl0 busy reads opcode", d, OE);
    rd(6'h02, d); chk("R8 ctl1 idle", d, 0);
    wait_idle(0); rd(6'h01, d); chk("R8 ctl0 done", d, 0);
    for (int k = 0; k < 8; k++) m_main[k] = '1;

    // R2 key discipline; each probe would erase bank0 page 0
    fill_wb(3); do_prog(0, 0, 0, 7); cmp_main("R2 setup");
    set_xfer(0, 0, 0, 0);
    wr(6'h01, OE); rd(6'h01, d); chk("R2 no key", d, 0);
    wr(6'h00, KEY); rd(6'h04, d); wr(6'h01, OE); rd(6'h01, d); chk("R2 read between", d, 0);
    wr(6'h00, KEY); set_xfer(0, 0, 0, 0); wr(6'h01, OE); rd(6'h01, d); chk("R2 write between", d, 0);
    wr(6'h00, KEY ^ 32'h1); wr(6'h01, OE); rd(6'h01, d); chk("R2 wrong key", d, 0);
    wr(6'h00, KEY); wr(6'h01, 32'h1234_5678); wr(6'h01, OE); rd(6'h01, d); chk("R2 key reused", d, 0);
    cmp_main("R2 array untouched");

    // R3 single-bit opcode corruptions
    for (int b = 0; b < 32; b++) begin
      launch(0, OE ^ (32'h1 << b));
      rd(6'h01, d); chk($sformatf("R3 bad opcode bit%0d", b), d, 0);
    end
    launch(0, 32'hFFFF_FFFF); rd(6'h01, d); chk("R3 all ones", d, 0);
    rd(6'h04, d); chk("R3 no error", d, 0);
    cmp_main("R3 array untouched");

    // R6 info region
    fill_wb(11); do_prog(1, 1, 2, 5);
    fill_wb(12); do_prog(1, 1, 15, 0);
    for (int j = 0; j < IWD; j++) begin
      set_xfer(j, 1, 0, 0); launch(1, OR); wait_idle(1);
      rd(6'h05, d); chk($sformatf("R6 info read %0d", j), d, m_info[j]);
    end
    set_xfer(0, 1, 0, 0); launch(1, OE); wait_idle(1);
    set_xfer(3, 1, 0, 0); launch(1, OR); wait_idle(1);
    rd(6'h05, d); chk("R6 info erased", d, 32'hFFFF_FFFF);
    cmp_main("R6 main untouched");

    // R7 rejects, R11 read-clear
    set_xfer(30, 0, 0, 2); launch(0, OP);
    rd(6'h01, d); chk("R7 prog past bank end", d, 0);
    rd(6'h04, d); chk("R7 err bit0", d, 1);
    rd(6'h04, d); chk("R11 err cleared", d, 0);
    set_xfer(BW, 0, 0, 0); launch(1, OE); rd(6'h04, d); chk("R7 erase off range", d, 1);
    set_xfer(0, 1, 0, 0); launch(0, OR); rd(6'h04, d); chk("R7 info via bank0", d, 1);
    set_xfer(0, 0, 0, 0); launch(1, OR); rd(6'h04, d); chk("R7 read without info", d, 1);
    set_xfer(12, 1, 0, 4); launch(1, OP); rd(6'h04, d); chk("R7 info prog range", d, 1);
    cmp_main("R7 array untouched");

    // R10 abort
    for (int i = 0; i < 8; i++) begin wb[i] = 0; wr(6'(32 + i), 0); end
    set_xfer(0, 0, 0, 7); launch(0, OP); wr(6'h01, 0);
    rd(6'h01, d); chk("R10 ctl0 after abort", d, 0);
    rd(6'h04, d); chk("R10 err bit1", d, 2);
    rd(6'h04, d); chk("R11 err cleared again", d, 0);
    repeat (PC + 2) @(posedge clk);
    cmp_main("R10 array untouched");

    // R12 command during a busy operation
    set_xfer(0, 0, 1, 0); launch(1, OE);
    set_xfer(0, 0, 0, 7); launch(0, OP);
    rd(6'h01, d); chk("R12 ctl0 not started", d, 0);
    wait_idle(1);
    for (int k = BW; k < 2 * BW; k++) m_main[k] = '1;
    rd(6'h04, d); chk("R12 no error", d, 0);
    cmp_main("R12 bank0 untouched");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule